// File: doc/BRIEF.md
# Inter-Burst Guard Delay Sequencer

This block steers the modulator input between two back-to-back transmit bursts. When a burst finishes, or when the next one begins (selected by a mode bit), it runs a programmable post-burst delay measured in quarter-symbol ticks. During the delay it stalls the data source and replaces the modulator input bit with a programmable guard value. When the delay expires, it releases one data bit with a single-cycle strobe and captures that bit. It then holds the guard value for a programmable number of further quarter-symbol ticks before it presents the captured bit.

In serial operation the block also issues a one-cycle mode strobe. Normally this strobe ends a gap count of master-clock ticks that starts when the delay expires. When the post-burst delay is programmed to zero, the whole delay, guard and gap sequence is skipped. In serial operation the mode strobe then waits for the next 16-master-clock boundary. The data source, the modulator, the DAC and the ramp shaping are outside this block. All outputs are registered, and the reset is synchronous and active high.

Top module: `burst_guard_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `hold`, `sel_guard`, `release_stb` and `mode_stb` are low. When idle, `mod_bit` follows `data_in` one cycle later.
- R2: With `cfg_late_start`=0, a falling edge of `tx_en` arms the block. The delay starts on the clock edge of the first `sym_end` pulse after that, and `hold` rises at that edge. Quarter ticks before the symbol end have no effect.
- R3: With `cfg_late_start`=1, the delay starts on the clock edge where a rising edge of `tx_en` is seen, and falling edges are ignored.
- R4: While the delay runs, `hold`=1, `sel_guard`=1 and `mod_bit` equals `cfg_guard_bit`.
- R5: The delay expires on the `cfg_post_dly`-th quarter tick after it starts. `release_stb` is then high for exactly one cycle.
- R6: With `cfg_post_dly`=0, a start event asserts neither `hold`, nor `sel_guard`, nor `release_stb`.
- R7: With `cfg_serial`=1, a gap count of `cfg_gap_len` master ticks starts at expiry, and `mode_stb` pulses on its last tick. A gap length of 0 pulses `mode_stb` together with `release_stb`. With `cfg_serial`=0, `mode_stb` never pulses.
- R8: With `cfg_post_dly`=0 and `cfg_serial`=1, `mode_stb` pulses on the next master tick whose count since reset is a multiple of 16.
- R9: After expiry, `sel_guard` and `hold` stay high for `cfg_guard_len` more quarter ticks. The bit that was on `data_in` at expiry is then driven on `mod_bit` until the next quarter tick, and after that `mod_bit` returns to live data.
- R10: With `cfg_guard_len`=0, the captured bit appears on `mod_bit` in the expiry cycle itself, with `hold` and `sel_guard` low.
- R11: A start event that arrives while a sequence is running (delay, guard, captured-bit phase, gap count or boundary wait) is ignored and does not restart the delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable strobe |
| qtr_tick | input | 1 | Quarter-symbol tick |
| sym_end | input | 1 | Symbol boundary strobe |
| mck_tick | input | 1 | Master-clock tick |
| data_in | input | 1 | Live data bit from FIFO or serial input |
| cfg_post_dly | input | CW | Post-burst delay in quarter ticks, 0 disables |
| cfg_guard_len | input | CW | Guard interval in quarter ticks |
| cfg_gap_len | input | GW | Serial gap count in master ticks |
| cfg_guard_bit | input | 1 | Guard default bit |
| cfg_late_start | input | 1 | 1: start on next burst rise; 0: after fall plus symbol end |
| cfg_serial | input | 1 | Serial data mode |
| hold | output | 1 | Stall FIFO / serial input |
| sel_guard | output | 1 | Modulator input takes the guard bit |
| mod_bit | output | 1 | Bit presented to the modulator |
| release_stb | output | 1 | One-cycle data release strobe |
| mode_stb | output | 1 | One-cycle mode strobe |

## Verification
Every output is a flop written from the next state. Each response therefore appears right after the clock edge that samples its cause: the start event, the expiring quarter tick, or the last master tick. No output responds on the next edge. The bench drives each stimulus for one cycle starting at a falling edge and reads the outputs at the following falling edge, half a period after the edge that was supposed to react. The delay, guard and gap lengths are counted pulse by pulse, so an off-by-one in any counter shows up as a strobe one pulse early or late. The 16-tick boundary is checked against the bench's own count of all master ticks sent since reset.

// File: rtl/bgs_pkg.sv
`timescale 1ns/1ps
package bgs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_DELAY,
    ST_GUARD,
    ST_FEED
  } seq_state_t;
endpackage

// File: rtl/bgs_downcount.sv
`timescale 1ns/1ps
// Loadable down counter; 'last' flags the tick that empties it.
module bgs_downcount #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         busy,
  output logic         last
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (tick && cnt != '0)
      cnt <= cnt - ONE;
  end

  assign busy = (cnt != '0);
  assign last = tick && (cnt == ONE);
endmodule

// File: rtl/bgs_mck_boundary.sv
`timescale 1ns/1ps
// Free-running master-tick phase counter and a one-shot boundary wait.
module bgs_mck_boundary #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic mck_tick,
  input  logic arm,
  output logic waiting,
  output logic hit
);
  localparam int MW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [MW-1:0] TOP = MW'(DIV - 1);

  logic [MW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst)
      phase <= '0;
    else if (mck_tick)
      phase <= (phase == TOP) ? '0 : phase + 1'b1;
  end

  assign hit = waiting && mck_tick && (phase == TOP);

  always_ff @(posedge clk) begin
    if (rst)
      waiting <= 1'b0;
    else if (hit)
      waiting <= 1'b0;
    else if (arm)
      waiting <= 1'b1;
  end
endmodule

// File: rtl/bgs_ctrl.sv
`timescale 1ns/1ps
// Sequence controller: start detection, delay, guard and captured-bit phases.
module bgs_ctrl
  import bgs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_en,
  input  logic       sym_end,
  input  logic       qtick,
  input  logic       dly_last,
  input  logic       grd_last,
  input  logic       side_busy,
  input  logic       dly_zero,
  input  logic       grd_zero,
  input  logic       late,
  input  logic       serial,
  output seq_state_t nxt,
  output logic       load_dly,
  output logic       load_grd,
  output logic       expire,
  output logic       arm_wait
);
  seq_state_t st;
  logic       tx_q;
  logic       tx_rise;
  logic       tx_fall;
  logic       go;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      tx_q <= 1'b0;
    end else begin
      st   <= nxt;
      tx_q <= tx_en;
    end
  end

  assign tx_rise = tx_en && !tx_q;
  assign tx_fall = !tx_en && tx_q;

  always_comb begin
    nxt      = st;
    load_dly = 1'b0;
    load_grd = 1'b0;
    expire   = 1'b0;
    arm_wait = 1'b0;
    go       = 1'b0;
    case (st)
      ST_IDLE: begin
        if (!side_busy) begin
          if (late && tx_rise)
            go = 1'b1;
          else if (!late && tx_fall)
            nxt = ST_ARM;
        end
      end
      ST_ARM: begin
        if (sym_end)
          go = 1'b1;
      end
      ST_DELAY: begin
        if (dly_last) begin
          expire = 1'b1;
          if (grd_zero)
            nxt = ST_FEED;
          else begin
            nxt      = ST_GUARD;
            load_grd = 1'b1;
          end
        end
      end
      ST_GUARD: begin
        if (grd_last)
          nxt = ST_FEED;
      end
      ST_FEED: begin
        if (qtick)
          nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
    if (go) begin
      if (dly_zero) begin
        nxt      = ST_IDLE;
        arm_wait = serial;
      end else begin
        nxt      = ST_DELAY;
        load_dly = 1'b1;
      end
    end
  end
endmodule

// File: rtl/burst_guard_seq.sv
`timescale 1ns/1ps
module burst_guard_seq
  import bgs_pkg::*;
#(
  parameter int CW      = 8,
  parameter int GW      = 8,
  parameter int MCK_DIV = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tx_en,
  input  logic          qtr_tick,
  input  logic          sym_end,
  input  logic          mck_tick,
  input  logic          data_in,
  input  logic [CW-1:0] cfg_post_dly,
  input  logic [CW-1:0] cfg_guard_len,
  input  logic [GW-1:0] cfg_gap_len,
  input  logic          cfg_guard_bit,
  input  logic          cfg_late_start,
  input  logic          cfg_serial,
  output logic          hold,
  output logic          sel_guard,
  output logic          mod_bit,
  output logic          release_stb,
  output logic          mode_stb
);
  localparam int NQ = 2;  // quarter-tick counters: 0 delay, 1 guard

  seq_state_t nxt;
  logic       load_dly, load_grd, expire, arm_wait;
  logic [NQ-1:0] q_load, q_busy, q_last;
  logic [CW-1:0] q_val [NQ];
  logic       gap_busy, gap_last, gap_load;
  logic       wait_busy, bnd_hit;
  logic       dly_zero, grd_zero, gap_zero;
  logic       cap_bit;
  logic       hold_n, feed_n;

  assign dly_zero = (cfg_post_dly == '0);
  assign grd_zero = (cfg_guard_len == '0);
  assign gap_zero = (cfg_gap_len == '0);

  assign q_load = {load_grd, load_dly};
  assign q_val[0] = cfg_post_dly;
  assign q_val[1] = cfg_guard_len;

  generate
    for (genvar i = 0; i < NQ; i++) begin : g_qcnt
      bgs_downcount #(.W(CW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (q_load[i]),
        .load_val (q_val[i]),
        .tick     (qtr_tick),
        .busy     (q_busy[i]),
        .last     (q_last[i])
      );
    end
  endgenerate

  assign gap_load = expire && cfg_serial && !gap_zero;

  bgs_downcount #(.W(GW)) u_gap (
    .clk      (clk),
    .rst      (rst),
    .load     (gap_load),
    .load_val (cfg_gap_len),
    .tick     (mck_tick),
    .busy     (gap_busy),
    .last     (gap_last)
  );

  bgs_mck_boundary #(.DIV(MCK_DIV)) u_bnd (
    .clk      (clk),
    .rst      (rst),
    .mck_tick (mck_tick),
    .arm      (arm_wait),
    .waiting  (wait_busy),
    .hit      (bnd_hit)
  );

  bgs_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .tx_en     (tx_en),
    .sym_end   (sym_end),
    .qtick     (qtr_tick),
    .dly_last  (q_last[0]),
    .grd_last  (q_last[1]),
    .side_busy (gap_busy || wait_busy || (|q_busy)),
    .dly_zero  (dly_zero),
    .grd_zero  (grd_zero),
    .late      (cfg_late_start),
    .serial    (cfg_serial),
    .nxt       (nxt),
    .load_dly  (load_dly),
    .load_grd  (load_grd),
    .expire    (expire),
    .arm_wait  (arm_wait)
  );

  assign hold_n = (nxt == ST_DELAY) || (nxt == ST_GUARD);
  assign feed_n = (nxt == ST_FEED);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold        <= 1'b0;
      sel_guard   <= 1'b0;
      mod_bit     <= 1'b0;
      release_stb <= 1'b0;
      mode_stb    <= 1'b0;
      cap_bit     <= 1'b0;
    end else begin
      hold        <= hold_n;
      sel_guard   <= hold_n;
      release_stb <= expire;
      mode_stb    <= cfg_serial && (gap_last || bnd_hit || (expire && gap_zero));
      if (expire)
        cap_bit <= data_in;
      if (hold_n)
        mod_bit <= cfg_guard_bit;
      else if (feed_n)
        mod_bit <= expire ? data_in : cap_bit;
      else
        mod_bit <= data_in;
    end
  end
endmodule

// File: rtl/bgs_checker.sv
`timescale 1ns/1ps
module bgs_checker #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          hold,
  input logic          sel_guard,
  input logic          mod_bit,
  input logic          release_stb,
  input logic          mode_stb,
  input logic          cfg_guard_bit,
  input logic          cfg_serial,
  input logic [CW-1:0] cfg_post_dly
);
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!hold && !sel_guard && !release_stb && !mode_stb));

  p_guard_needs_hold_r4: assert property (@(posedge clk) disable iff (rst)
    sel_guard |-> hold);

  p_guard_value_r4: assert property (@(posedge clk) disable iff (rst)
    (sel_guard && !$past(rst)) |-> (mod_bit == $past(cfg_guard_bit)));

  p_release_single_r5: assert property (@(posedge clk) disable iff (rst)
    release_stb |=> !release_stb);

  p_release_after_hold_r5: assert property (@(posedge clk) disable iff (rst)
    release_stb |-> $past(hold));

  p_hold_needs_delay_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(hold) |-> ($past(cfg_post_dly) != '0));

  p_mode_serial_r7: assert property (@(posedge clk) disable iff (rst)
    mode_stb |-> $past(cfg_serial));

  p_mode_single_r7: assert property (@(posedge clk) disable iff (rst)
    mode_stb |=> !mode_stb);
endmodule

bind burst_guard_seq bgs_checker #(.CW(CW)) u_bgs_chk (
  .clk           (clk),
  .rst           (rst),
  .hold          (hold),
  .sel_guard     (sel_guard),
  .mod_bit       (mod_bit),
  .release_stb   (release_stb),
  .mode_stb      (mode_stb),
  .cfg_guard_bit (cfg_guard_bit),
  .cfg_serial    (cfg_serial),
  .cfg_post_dly  (cfg_post_dly)
);

// File: tb/burst_guard_seq_test.sv
`timescale 1ns/1ps
module burst_guard_seq_test;
  localparam int CW = 8;
  localparam int GW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_en = 1'b0, qtr_tick = 1'b0, sym_end = 1'b0, mck_tick = 1'b0, data_in = 1'b0;
  logic [CW-1:0] cfg_post_dly = '0, cfg_guard_len = '0;
  logic [GW-1:0] cfg_gap_len = '0;
  logic cfg_guard_bit = 1'b0, cfg_late_start = 1'b0, cfg_serial = 1'b0;
  logic hold, sel_guard, mod_bit, release_stb, mode_stb;

  int checks = 0;
  int errors = 0;
  int mck_total = 0;
  int ms_cnt = 0;
  int rel_cnt = 0;

  always #10 clk = ~clk;

  burst_guard_seq #(.CW(CW), .GW(GW), .MCK_DIV(16)) uut (
    .clk(clk), .rst(rst), .tx_en(tx_en), .qtr_tick(qtr_tick), .sym_end(sym_end),
    .mck_tick(mck_tick), .data_in(data_in), .cfg_post_dly(cfg_post_dly),
    .cfg_guard_len(cfg_guard_len), .cfg_gap_len(cfg_gap_len),
    .cfg_guard_bit(cfg_guard_bit), .cfg_late_start(cfg_late_start),
    .cfg_serial(cfg_serial), .hold(hold), .sel_guard(sel_guard), .mod_bit(mod_bit),
    .release_stb(release_stb), .mode_stb(mode_stb)
  );

  always @(posedge clk) begin
    if (!rst) begin
      if (mode_stb) ms_cnt++;
      if (release_stb) rel_cnt++;
    end
  end

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse_q();
    qtr_tick = 1'b1; @(negedge clk); qtr_tick = 1'b0;
  endtask

  task automatic pulse_sym();
    sym_end = 1'b1; @(negedge clk); sym_end = 1'b0;
  endtask

  task automatic pulse_mck();
    mck_tick = 1'b1; @(negedge clk); mck_tick = 1'b0; mck_total++;
  endtask

  task automatic t_reset();
    check("R1", "hold in reset", hold, 0);
    check("R1", "sel_guard in reset", sel_guard, 0);
    data_in = 1'b1;
    rst = 1'b0;
    step();
    check("R1", "hold after reset", hold, 0);
    check("R1", "release after reset", release_stb, 0);
    check("R1", "mode after reset", mode_stb, 0);
    check("R1", "mod_bit follows data", mod_bit, 1);
    data_in = 1'b0; step();
    check("R1", "mod_bit follows data low", mod_bit, 0);
  endtask

  task automatic t_normal_mode();
    int ms0;
    ms0 = ms_cnt;
    cfg_late_start = 1'b0; cfg_serial = 1'b0;
    cfg_post_dly = 8'd3; cfg_guard_len = 8'd2; cfg_guard_bit = 1'b0; data_in = 1'b1;
    tx_en = 1'b1; step(); step();
    check("R2", "no start on rise", hold, 0);
    tx_en = 1'b0; step(); step();
    check("R2", "armed, waiting for symbol end", hold, 0);
    pulse_q();
    check("R2", "quarter tick before symbol end", hold, 0);
    pulse_sym();
    check("R2", "hold at symbol end", hold, 1);
    check("R4", "sel_guard during delay", sel_guard, 1);
    check("R4", "guard bit on mod_bit", mod_bit, 0);
    pulse_q(); pulse_q();
    check("R5", "no release before last tick", release_stb, 0);
    check("R4", "still holding", hold, 1);
    pulse_q();
    check("R5", "release on 3rd tick", release_stb, 1);
    data_in = 1'b0;
    step();
    check("R5", "release single cycle", release_stb, 0);
    check("R9", "guard after expiry", sel_guard, 1);
    check("R9", "guard bit during guard", mod_bit, 0);
    pulse_q();
    check("R9", "guard still after 1 tick", sel_guard, 1);
    pulse_q();
    check("R9", "guard ends after 2 ticks", sel_guard, 0);
    check("R9", "hold released", hold, 0);
    check("R9", "captured bit on mod_bit", mod_bit, 1);
    pulse_q();
    check("R9", "live data after feed", mod_bit, 0);
    step();
    check("R7", "no mode strobe when not serial", ms_cnt - ms0, 0);
  endtask

  task automatic t_late_guard_zero();
    cfg_late_start = 1'b1; cfg_serial = 1'b1;
    cfg_post_dly = 8'd2; cfg_guard_len = 8'd0; cfg_gap_len = 8'd3;
    cfg_guard_bit = 1'b1; data_in = 1'b0;
    tx_en = 1'b1; step();
    check("R3", "hold on rising edge", hold, 1);
    check("R4", "guard bit 1 on mod_bit", mod_bit, 1);
    pulse_q();
    check("R5", "no release after 1 tick", release_stb, 0);
    pulse_q();
    check("R5", "release after 2 ticks", release_stb, 1);
    check("R10", "hold low at expiry", hold, 0);
    check("R10", "sel_guard low at expiry", sel_guard, 0);
    check("R10", "captured bit at expiry", mod_bit, 0);
    data_in = 1'b1; step();
    check("R10", "captured bit persists", mod_bit, 0);
    pulse_mck(); pulse_mck();
    check("R7", "no mode strobe before last gap tick", mode_stb, 0);
    pulse_mck();
    check("R7", "mode strobe on 3rd gap tick", mode_stb, 1);
    pulse_q();
    check("R7", "mode strobe single", mode_stb, 0);
    tx_en = 1'b0; step(); step();
    check("R3", "fall ignored in late mode", hold, 0);
  endtask

  task automatic t_gap_zero();
    cfg_late_start = 1'b1; cfg_serial = 1'b1;
    cfg_post_dly = 8'd1; cfg_guard_len = 8'd1; cfg_gap_len = 8'd0;
    tx_en = 1'b1; step();
    pulse_q();
    check("R7", "release with zero gap", release_stb, 1);
    check("R7", "mode strobe with release", mode_stb, 1);
    pulse_q(); pulse_q();
    tx_en = 1'b0; step();
  endtask

  task automatic t_zero_delay_plain();
    int r0;
    r0 = rel_cnt;
    cfg_late_start = 1'b1; cfg_serial = 1'b0; cfg_post_dly = 8'd0;
    tx_en = 1'b1; step();
    check("R6", "no hold with zero delay", hold, 0);
    pulse_q(); pulse_q(); pulse_q();
    check("R6", "no sel_guard with zero delay", sel_guard, 0);
    check("R6", "no release with zero delay", rel_cnt - r0, 0);
    tx_en = 1'b0; step();
  endtask

  task automatic t_zero_delay_serial();
    cfg_late_start = 1'b1; cfg_serial = 1'b1; cfg_post_dly = 8'd0;
    tx_en = 1'b1; step();
    check("R8", "no hold with zero delay serial", hold, 0);
    for (int i = 0; i < 17; i++) begin
      bit at_bnd;
      pulse_mck();
      at_bnd = (mck_total % 16) == 0;
      check("R8", "mode strobe only at 16-tick boundary", mode_stb, at_bnd);
      if (at_bnd) break;
    end
    step();
    check("R8", "mode strobe one cycle", mode_stb, 0);
    tx_en = 1'b0; step();
  endtask

  task automatic t_busy_ignore();
    cfg_late_start = 1'b1; cfg_serial = 1'b0;
    cfg_post_dly = 8'd4; cfg_guard_len = 8'd0;
    tx_en = 1'b1; step();
    pulse_q(); pulse_q();
    tx_en = 1'b0; step();
    tx_en = 1'b1; step();
    check("R11", "hold kept during restart attempt", hold, 1);
    pulse_q();
    check("R11", "no release on 3rd tick", release_stb, 0);
    pulse_q();
    check("R11", "release on original 4th tick", release_stb, 1);
    pulse_q();
    tx_en = 1'b0; step();
  endtask

  initial begin
    step(); step(); step();
    t_reset();
    t_normal_mode();
    t_late_guard_zero();
    t_gap_zero();
    t_zero_delay_plain();
    t_zero_delay_serial();
    t_busy_ignore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule